// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a local-oscillator input by a programmable divisor N and emits one single-cycle pulse for every N input cycles. The phase comparator of a frequency synthesizer uses that pulse. Both oscillator inputs arrive as one-cycle tick strobes in the block's clock domain. `hiBandTick` is the high-band source and `loBandTick` is the low-band source. Each tick stands for one oscillator cycle. The counters are all synchronous to `clk`.

Two select bits are captured on a load strobe together with a 16-bit divisor word. They choose one of three ways of dividing:

- **Prescaled swallow.** A fixed divide-by-two feeds a dual-modulus swallow stage, so the high-band input is divided by 2N.
- **Plain swallow.** The swallow stage alone divides the low-band input by N.
- **Direct.** A 12-bit counter divides the low-band input by the upper twelve bits of the word.

The swallow stage is built from three counters:

- A 4-bit swallow counter A, taken from the low four bits of the word.
- A 12-bit main counter B, taken from the upper twelve bits.
- A 16/17 prescaler. It divides by 17 while A has not run out and by 16 afterwards, which gives N = 16·B + A.

A newly loaded setting waits for the current output period to finish before it takes effect. An inhibit level halts the divider, and the first period after release starts fresh.

Top module: `swallowDivider`

## Requirements
- R1: While `rstN` is low and after reset with no input ticks, `divOut` stays 0.
- R2: With `selHighBand`=1 at load, the spacing between output pulses is 2·N `hiBandTick` ticks, N being the 16-bit word; `selWideRange` has no effect in this mode.
- R3: With `selHighBand`=0 and `selWideRange`=1, the spacing is N `loBandTick` ticks for N in 272..65535.
- R4: With both select bits 0, the spacing is `divisorWord[15:4]` `loBandTick` ticks (4..4095), and `divisorWord[3:0]` has no effect.
- R5: Ticks on the input that the active mode does not select have no effect on the pulse spacing.
- R6: In the swallow modes the prescaler divides by 17 for A = `divisorWord[3:0]` of its cycles and by 16 for the rest, which is exact for A = 0 and A = 15 at the smallest legal B of 17.
- R7: In the two swallow modes a word below 272 acts as 272.
- R8: In direct mode a value of `divisorWord[15:4]` below 4 acts as 4.
- R9: A load made while the divider runs does not change the period in progress. That period completes with the old setting, mode included, and the new setting governs every later period.
- R10: While `inhibit` is high no pulse is produced and ticks are not counted. After release the first pulse comes after a full period counted from the release.
- R11: A setting loaded while `inhibit` is high governs the very first period after release.
- R12: `divOut` is high for exactly one clock cycle per period. It rises in the cycle after the clock edge that captured the period's final tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| hiBandTick | input | 1 | One-cycle strobe per high-band oscillator cycle |
| loBandTick | input | 1 | One-cycle strobe per low-band oscillator cycle |
| selHighBand | input | 1 | Mode bit: 1 selects the high-band input with divide-by-two |
| selWideRange | input | 1 | Mode bit for the low band: 1 swallow, 0 direct |
| divisorWord | input | 16 | Divisor N (direct mode uses bits 15:4) |
| loadStrobe | input | 1 | Captures the select bits and the divisor word |
| inhibit | input | 1 | Level: halt the divider and restart on release |
| divOut | output | 1 | One-cycle pulse per N selected input cycles |

## Verification
The hardest situation to reach from the ports is a load that lands in the middle of a running period. That load must not disturb the period, and for a mode switch the pulse after it must be counted on a possibly different input. The stimulus lets a period start and waits a fixed number of cycles short of its end. It then pulses the load with a new divisor, and in a second round with a new mode. The scoreboard expects one pulse at the old spacing followed by pulses at the new one. The 17/16 switching inside the swallow stage is reached with divisors whose low nibble is 0 or 15 at the smallest main count. A second input is kept ticking throughout, so that any leakage from the unselected source shows up as a spacing error.

// File: rtl/swallowDividerPkg.sv
package swallowDividerPkg;

  // Division scheme held for the period in progress
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_SWALLOW  = 2'd1,
    MODE_PRESCALE = 2'd2
  } divMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;  // hold everything at period start, suppress output
    logic reload;   // load counters from the pending setting at this edge
  } divStrobe_s;

endpackage

// File: rtl/swallowDividerCtrl.sv
module swallowDividerCtrl
  import swallowDividerPkg::*;
#(
  parameter int SWALLOW_W  = 4,
  parameter int MAIN_W     = 12,
  parameter int DIRECT_MIN = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         selHighBand,
  input  logic                         selWideRange,
  input  logic [SWALLOW_W+MAIN_W-1:0]  divisorWord,
  input  logic                         loadStrobe,
  input  logic                         inhibit,
  input  logic                         periodEnd,
  output divStrobe_s                   strobe,
  output divMode_e                     activeMode,
  output logic [SWALLOW_W-1:0]         loadSwallow,
  output logic [MAIN_W-1:0]            loadMain
);

  localparam int WORD_W      = SWALLOW_W + MAIN_W;
  localparam int PSC_SMALL   = 1 << SWALLOW_W;
  localparam int SWALLOW_MIN = PSC_SMALL * (PSC_SMALL + 1);

  divMode_e            pendMode;
  logic [WORD_W-1:0]   pendWord;
  logic [WORD_W-1:0]   swallowVal;
  logic [MAIN_W-1:0]   directVal;

  // Pending setting: written by every load, copied out at each boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMode <= MODE_DIRECT;
      pendWord <= '0;
    end else if (loadStrobe) begin
      pendWord <= divisorWord;
      if (selHighBand)       pendMode <= MODE_PRESCALE;
      else if (selWideRange) pendMode <= MODE_SWALLOW;
      else                   pendMode <= MODE_DIRECT;
    end
  end

  // Floor the pending divisor to the mode's minimum and split it into counter loads
  always_comb begin
    swallowVal = (pendWord < WORD_W'(SWALLOW_MIN)) ? WORD_W'(SWALLOW_MIN) : pendWord;
    directVal  = pendWord[WORD_W-1:SWALLOW_W];
    if (directVal < MAIN_W'(DIRECT_MIN)) directVal = MAIN_W'(DIRECT_MIN);
    if (pendMode == MODE_DIRECT) begin
      loadMain    = directVal;
      loadSwallow = '0;
    end else begin
      loadMain    = swallowVal[WORD_W-1:SWALLOW_W];
      loadSwallow = swallowVal[SWALLOW_W-1:0];
    end
  end

  always_comb begin
    strobe.restart = inhibit;
    strobe.reload  = inhibit | periodEnd;
  end

  // Mode in force for the running period; changes only at a boundary
  always_ff @(posedge clk) begin
    if (!rstN)              activeMode <= MODE_DIRECT;
    else if (strobe.reload) activeMode <= pendMode;
  end

  // R9: a load between boundaries leaves the running mode untouched
  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && !inhibit && !periodEnd) |=> (activeMode == $past(activeMode)));

  // R7: swallow loads never fall below the smallest legal divisor
  assert_swallow_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pendMode != MODE_DIRECT) |-> ({loadMain, loadSwallow} >= WORD_W'(SWALLOW_MIN)));

  // R8: direct loads never fall below the direct minimum
  assert_direct_floor_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pendMode == MODE_DIRECT) |-> (loadMain >= MAIN_W'(DIRECT_MIN)));

endmodule

// File: rtl/swallowDividerPath.sv
module swallowDividerPath
  import swallowDividerPkg::*;
#(
  parameter int SWALLOW_W  = 4,
  parameter int MAIN_W     = 12,
  parameter int DIRECT_MIN = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hiBandTick,
  input  logic                  loBandTick,
  input  divStrobe_s            strobe,
  input  divMode_e              activeMode,
  input  logic [SWALLOW_W-1:0]  loadSwallow,
  input  logic [MAIN_W-1:0]     loadMain,
  output logic                  periodEnd,
  output logic                  divOut
);

  localparam int PSC_SMALL = 1 << SWALLOW_W;
  localparam int PSC_W     = SWALLOW_W + 1;
  localparam logic [PSC_W-1:0] LAST_BIG   = PSC_W'(PSC_SMALL);
  localparam logic [PSC_W-1:0] LAST_SMALL = PSC_W'(PSC_SMALL - 1);

  logic                  halfPhase;
  logic [PSC_W-1:0]      pscCnt;
  logic [SWALLOW_W-1:0]  swallowLeft;
  logic [MAIN_W-1:0]     mainLeft;
  logic                  stageTick;
  logic [PSC_W-1:0]      modLast;
  logic                  pscOut;
  logic                  mainStep;

  always_comb begin
    case (activeMode)
      MODE_PRESCALE: stageTick = hiBandTick & halfPhase;  // every second high-band tick
      MODE_SWALLOW:  stageTick = loBandTick;
      default:       stageTick = 1'b0;
    endcase
    // Divide by 17 while swallow cycles remain, by 16 afterwards
    modLast   = (swallowLeft != '0) ? LAST_BIG : LAST_SMALL;
    pscOut    = stageTick && (pscCnt == modLast);
    mainStep  = (activeMode == MODE_DIRECT) ? loBandTick : pscOut;
    periodEnd = mainStep && (mainLeft == MAIN_W'(1)) && !strobe.restart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfPhase   <= 1'b0;
      pscCnt      <= '0;
      swallowLeft <= '0;
      mainLeft    <= MAIN_W'(DIRECT_MIN);
      divOut      <= 1'b0;
    end else begin
      divOut <= periodEnd;
      if (strobe.reload) begin
        halfPhase   <= 1'b0;
        pscCnt      <= '0;
        swallowLeft <= loadSwallow;
        mainLeft    <= loadMain;
      end else begin
        if (activeMode == MODE_PRESCALE && hiBandTick) halfPhase <= ~halfPhase;
        if (stageTick)                     pscCnt      <= pscOut ? '0 : pscCnt + 1'b1;
        if (pscOut && swallowLeft != '0)   swallowLeft <= swallowLeft - 1'b1;
        if (mainStep)                      mainLeft    <= mainLeft - 1'b1;
      end
    end
  end

  // R6: the dual-modulus count never passes the divide-by-17 terminal value
  assert_psc_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    pscCnt <= LAST_BIG);

  // R3: the main counter never sits at zero, so every period ends
  assert_main_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    mainLeft != '0);

  // R10: a halted cycle produces no pulse
  assert_quiet_inhibit_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> !divOut);

  // R12: output pulses are one cycle wide
  assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rstN)
    divOut |=> !divOut);

endmodule

// File: rtl/swallowDivider.sv
module swallowDivider
  import swallowDividerPkg::*;
#(
  parameter int SWALLOW_W  = 4,
  parameter int MAIN_W     = 12,
  parameter int DIRECT_MIN = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hiBandTick,
  input  logic                         loBandTick,
  input  logic                         selHighBand,
  input  logic                         selWideRange,
  input  logic [SWALLOW_W+MAIN_W-1:0]  divisorWord,
  input  logic                         loadStrobe,
  input  logic                         inhibit,
  output logic                         divOut
);

  divStrobe_s            strobe;
  divMode_e              activeMode;
  logic [SWALLOW_W-1:0]  loadSwallow;
  logic [MAIN_W-1:0]     loadMain;
  logic                  periodEnd;

  swallowDividerCtrl #(
    .SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W), .DIRECT_MIN(DIRECT_MIN)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .selHighBand(selHighBand), .selWideRange(selWideRange),
    .divisorWord(divisorWord), .loadStrobe(loadStrobe), .inhibit(inhibit),
    .periodEnd(periodEnd), .strobe(strobe), .activeMode(activeMode),
    .loadSwallow(loadSwallow), .loadMain(loadMain)
  );

  swallowDividerPath #(
    .SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W), .DIRECT_MIN(DIRECT_MIN)
  ) path (
    .clk(clk), .rstN(rstN),
    .hiBandTick(hiBandTick), .loBandTick(loBandTick),
    .strobe(strobe), .activeMode(activeMode),
    .loadSwallow(loadSwallow), .loadMain(loadMain),
    .periodEnd(periodEnd), .divOut(divOut)
  );

endmodule

// File: tb/swallowDivider_test.sv
module swallowDivider_test;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hiBandTick = 1'b0;
  logic        loBandTick = 1'b0;
  logic        selHighBand = 1'b0;
  logic        selWideRange = 1'b0;
  logic [15:0] divisorWord = '0;
  logic        loadStrobe = 1'b0;
  logic        inhibit = 1'b0;
  logic        divOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallowDivider uut (
    .clk(clk), .rstN(rstN), .hiBandTick(hiBandTick), .loBandTick(loBandTick),
    .selHighBand(selHighBand), .selWideRange(selWideRange),
    .divisorWord(divisorWord), .loadStrobe(loadStrobe), .inhibit(inhibit),
    .divOut(divOut)
  );

  typedef struct {
    int    spacing;
    bit    useHi;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, fails = 0;
  int hiCount = 0, loCount = 0, hiMark = 0, loMark = 0;
  int hiStyle = 0, loStyle = 0;  // 0 idle, 1 every cycle, 2 random
  bit quiet = 1'b0;
  int quietPulses = 0;
  int widePulses = 0;
  bit lastOut = 1'b0;
  int cycle = 0;
  bit done = 1'b0;

  // Expected spacing from the requirements (R2, R3, R4, R7, R8)
  function automatic int expSpacing(bit hi, bit rng, logic [15:0] w);
    int n;
    if (hi || rng) begin
      n = (w < 16'd272) ? 272 : int'(w);
      return hi ? 2 * n : n;
    end
    n = int'(w[15:4]);
    return (n < 4) ? 4 : n;
  endfunction

  function automatic bit pick(int style);
    if (style == 1) return 1'b1;
    if (style == 2) return 1'(($urandom_range(0, 1)));
    return 1'b0;
  endfunction

  // Tick generator: drives both inputs at the falling edge and counts them
  always @(negedge clk) begin
    bit h, l;
    h = pick(hiStyle);
    l = pick(loStyle);
    hiBandTick = h;
    loBandTick = l;
    if (h) hiCount++;
    if (l) loCount++;
  end

  // Monitor: samples after the rising edge and scores each pulse
  always @(posedge clk) begin
    #1;
    cycle++;
    if (rstN && divOut) begin
      if (lastOut) widePulses++;
      if (quiet) begin
        quietPulses++;
      end else begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R9: unexpected pulse at cycle %0d, actual 1 expected 0", cycle);
        end else begin
          expItem_t it;
          int delta;
          it = expQ.pop_front();
          delta = it.useHi ? (hiCount - hiMark) : (loCount - loMark);
          if (delta != it.spacing) begin
            fails++;
            $display("FAIL %s: pulse spacing actual %0d expected %0d", it.req, delta, it.spacing);
          end
        end
      end
      hiMark = hiCount;
      loMark = loCount;
    end
    lastOut = divOut;
    if (cycle >= WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycle);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // Loads a setting while halted, so it governs the first period after release (R11)
  task automatic configure(bit hi, bit rng, logic [15:0] w);
    hiStyle = 0;
    loStyle = 0;
    @(negedge clk);
    inhibit = 1'b1;
    selHighBand = hi;
    selWideRange = rng;
    divisorWord = w;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    cycles(2);
    inhibit = 1'b0;
    hiMark = hiCount;
    loMark = loCount;
  endtask

  // Loads without halting (R9)
  task automatic liveLoad(bit hi, bit rng, logic [15:0] w);
    @(negedge clk);
    selHighBand = hi;
    selWideRange = rng;
    divisorWord = w;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic expectPulses(int spacing, bit useHi, int reps, string req);
    for (int i = 0; i < reps; i++) begin
      expItem_t it;
      it.spacing = spacing;
      it.useHi = useHi;
      it.req = req;
      expQ.push_back(it);
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    cycles(4);
    checks++;
    if (divOut !== 1'b0) begin
      fails++;
      $display("FAIL R1: divOut in reset actual %b expected 0", divOut);
    end
    rstN = 1'b1;
    cycles(5);
    checks++;
    if (divOut !== 1'b0) begin
      fails++;
      $display("FAIL R1: divOut idle actual %b expected 0", divOut);
    end

    // R2: prescaled swallow, range bit 0, low band noisy (R5)
    configure(1'b1, 1'b0, 16'd300);
    expectPulses(expSpacing(1'b1, 1'b0, 16'd300), 1'b1, 3, "R2");
    hiStyle = 1; loStyle = 2;
    drain();

    // R2: range bit 1 ignored, sparse high-band ticks
    configure(1'b1, 1'b1, 16'd1386);
    expectPulses(expSpacing(1'b1, 1'b1, 16'd1386), 1'b1, 2, "R2");
    hiStyle = 2; loStyle = 1;
    drain();

    // R6: A = 0 at the smallest main count, high band noisy (R5)
    configure(1'b0, 1'b1, 16'd272);
    expectPulses(272, 1'b0, 2, "R6");
    hiStyle = 1; loStyle = 2;
    drain();

    // R6: A = 15 with B = 17
    configure(1'b0, 1'b1, 16'd287);
    expectPulses(287, 1'b0, 2, "R6");
    hiStyle = 1; loStyle = 2;
    drain();

    // R3: larger swallow divisor
    configure(1'b0, 1'b1, 16'd4660);
    expectPulses(expSpacing(1'b0, 1'b1, 16'd4660), 1'b0, 2, "R3");
    hiStyle = 2; loStyle = 2;
    drain();

    // R4: direct, low nibble ignored, high band ticking (R5)
    configure(1'b0, 1'b0, 16'h0097);
    expectPulses(9, 1'b0, 4, "R4");
    hiStyle = 1; loStyle = 2;
    drain();

    // R4: direct maximum
    configure(1'b0, 1'b0, 16'hFFF0);
    expectPulses(4095, 1'b0, 1, "R4");
    hiStyle = 0; loStyle = 1;
    drain();

    // R8: direct value 2 acts as 4
    configure(1'b0, 1'b0, 16'h002F);
    expectPulses(4, 1'b0, 3, "R8");
    hiStyle = 2; loStyle = 1;
    drain();

    // R7: swallow word 100 acts as 272
    configure(1'b0, 1'b1, 16'd100);
    expectPulses(272, 1'b0, 2, "R7");
    hiStyle = 1; loStyle = 1;
    drain();

    // R7: prescaled word 5 acts as 272, so 544 high-band ticks
    configure(1'b1, 1'b0, 16'd5);
    expectPulses(544, 1'b1, 2, "R7");
    hiStyle = 1; loStyle = 1;
    drain();

    // R9: divisor change mid-period
    configure(1'b0, 1'b1, 16'd300);
    expectPulses(300, 1'b0, 1, "R9");
    hiStyle = 2; loStyle = 1;
    drain();
    cycles(100);
    liveLoad(1'b0, 1'b1, 16'd500);
    expectPulses(300, 1'b0, 1, "R9");
    expectPulses(500, 1'b0, 2, "R9");
    drain();

    // R9: mode change mid-period, swallow to direct
    cycles(50);
    liveLoad(1'b0, 1'b0, 16'h0070);
    expectPulses(500, 1'b0, 1, "R9");
    expectPulses(7, 1'b0, 3, "R9");
    drain();

    // R10: halt mid-period while ticks keep arriving
    configure(1'b0, 1'b1, 16'd300);
    expectPulses(300, 1'b0, 1, "R10");
    hiStyle = 1; loStyle = 1;
    drain();
    cycles(50);
    inhibit = 1'b1;
    quiet = 1'b1;
    cycles(400);
    checks++;
    if (quietPulses != 0) begin
      fails++;
      $display("FAIL R10: pulses while halted actual %0d expected 0", quietPulses);
    end

    // R11: load while halted, then a full fresh period after release
    liveLoad(1'b0, 1'b1, 16'd280);
    hiStyle = 0; loStyle = 0;
    cycles(2);
    inhibit = 1'b0;
    quiet = 1'b0;
    hiMark = hiCount;
    loMark = loCount;
    expectPulses(280, 1'b0, 2, "R11");
    hiStyle = 1; loStyle = 2;
    drain();

    hiStyle = 0; loStyle = 0;
    cycles(3);

    // R12: every pulse one cycle wide
    checks++;
    if (widePulses != 0) begin
      fails++;
      $display("FAIL R12: wide pulses actual %0d expected 0", widePulses);
    end
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R9: pending expectations actual %0d expected 0", expQ.size());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule